// File: doc/BRIEF.md
# Priority-Group Round-Robin Arbiter

This block chooses which of several bus masters may drive a shared interconnect next. Software gives every master a two-bit priority level, where 0 is the most urgent and 3 the least. Masters with the same level form a group. The group with the most urgent level that has an active requester wins. Inside that group, service rotates round robin in ascending master index and wraps after the last master.

A mode input sets how often the decision is made. In per-beat mode the arbiter decides again after every completed transfer, so bursts from different masters can interleave at beat granularity. In per-burst mode the winner keeps the grant until it completes a transfer with its last-beat flag set. The grant is a registered one-hot vector, or all zeros when nobody is served.

Top module: `prio_rr_arbiter`

## Requirements
- R1: Reset behaviour.
  - While reset is low and in the first cycle after it, the grant is all zeros.
  - Every master's priority level resets to 3.
  - Every round-robin pointer resets so that master 0 is the first candidate of its level.
- R2: The grant output is registered and is one-hot or zero. Bit i of `grant` stands for master i. A master that newly receives the grant had its `req` bit high in the cycle before.
- R3: Priority order.
  - At an arbitration point, the grant goes to a requester whose level is numerically lowest among all requesters.
  - Level 0 wins over 1, 1 over 2, and 2 over 3.
- R4: Round robin inside a level.
  - The winner is the first requester of that level found by searching upward from the last master that completed a transfer at that level, wrapping from the highest index to 0.
  - Each level keeps its own pointer.
- R5: Per-beat mode.
  - With `mode_burst`=0, every completed transfer is an arbitration point.
  - A transfer is complete in a cycle where `xfer_valid` and `xfer_ready` are both high and the grant is nonzero.
- R6: Per-burst mode.
  - With `mode_burst`=1, a completed transfer is an arbitration point only when the `last` bit of the granted master is high.
  - Otherwise the grant is held.
- R7: While a master holds the grant and no transfer completes, the grant does not change.
- R8: Idle behaviour.
  - If no master requests at an arbitration point, the grant becomes zero.
  - The round-robin pointers change only in a cycle with a completed transfer.
- R9: Priority writes.
  - A write with `cfg_we`=1 sets the level of master `cfg_idx` to `cfg_prio` at the clock edge.
  - The new level is used only at later arbitration points and does not break a locked burst.
- R10: While the grant is zero, every cycle is an arbitration point, so any request is granted in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_burst | input | 1 | 0: arbitrate on every beat; 1: arbitrate once per burst |
| req | input | NUM_MASTERS | Request bit per master |
| last | input | NUM_MASTERS | Last-beat flag per master |
| xfer_valid | input | 1 | Granted master presents a transfer |
| xfer_ready | input | 1 | Interconnect accepts the transfer |
| cfg_we | input | 1 | Priority write strobe |
| cfg_idx | input | IDX_W | Master whose level is written |
| cfg_prio | input | 2 | New priority level (0 highest) |
| grant | output | NUM_MASTERS | Registered one-hot grant |

## Verification
On every cycle the assertions check that the grant is one-hot or zero and goes only to a master that was requesting. They also check that the grant is held when no transfer completes and through the non-final beats of a locked burst. Further properties check that an arbitration point with requesters always yields a grant, that one with no requesters yields none, and that the pointers stay still without a completion. Whether the right master wins by level and rotation order, and when a changed priority takes effect, can only be shown by the bench. The bench sweeps every priority assignment for four masters and compares each cycle with its own arithmetic model of the group and pointer rules.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int PRIO_W     = 2;
  localparam int NUM_LEVELS = 1 << PRIO_W;

  typedef logic [PRIO_W-1:0] prio_t;

  localparam prio_t PRIO_RESET = '1;

  typedef enum logic {
    ARB_PER_BEAT  = 1'b0,
    ARB_PER_BURST = 1'b1
  } arb_mode_e;
endpackage

// File: rtl/prio_cfg_regs.sv
module prio_cfg_regs
  import arb_pkg::*;
#(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_idx,
  input  prio_t                 wr_val,
  output logic [N*PRIO_W-1:0]   prio_flat
);
  generate
    for (genvar i = 0; i < N; i++) begin : g_reg
      prio_t lvl_q;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          lvl_q <= PRIO_RESET;
        end else if (wr_en && (int'(wr_idx) == i)) begin
          lvl_q <= wr_val;
        end
      end
      assign prio_flat[i*PRIO_W +: PRIO_W] = lvl_q;
    end
  endgenerate
endmodule

// File: rtl/level_select.sv
module level_select
  import arb_pkg::*;
#(
  parameter int N = 4
) (
  input  logic [N-1:0]            req,
  input  logic [N*PRIO_W-1:0]     prio_flat,
  output logic [NUM_LEVELS*N-1:0] lvl_masks,
  output prio_t                   best_lvl,
  output logic                    any_req
);
  function automatic prio_t most_urgent(input logic [NUM_LEVELS*N-1:0] m);
    prio_t r;
    logic  hit;
    r   = '0;
    hit = 1'b0;
    for (int l = 0; l < NUM_LEVELS; l++) begin
      if (!hit && (|m[l*N +: N])) begin
        hit = 1'b1;
        r   = prio_t'(l);
      end
    end
    return r;
  endfunction

  generate
    for (genvar l = 0; l < NUM_LEVELS; l++) begin : g_lvl
      for (genvar i = 0; i < N; i++) begin : g_m
        assign lvl_masks[l*N + i] = req[i] &&
          (prio_flat[i*PRIO_W +: PRIO_W] == prio_t'(l));
      end
    end
  endgenerate

  assign best_lvl = most_urgent(lvl_masks);
  assign any_req  = |req;
endmodule

// File: rtl/rr_pointer_bank.sv
module rr_pointer_bank
  import arb_pkg::*;
#(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        upd_en,
  input  prio_t                       upd_lvl,
  input  logic [IDX_W-1:0]            upd_idx,
  output logic [NUM_LEVELS*IDX_W-1:0] ptr_q_flat,
  output logic [NUM_LEVELS*IDX_W-1:0] ptr_eff_flat
);
  localparam logic [IDX_W-1:0] PTR_RESET = IDX_W'(N - 1);

  generate
    for (genvar l = 0; l < NUM_LEVELS; l++) begin : g_ptr
      logic [IDX_W-1:0] p_q;
      logic             hit;
      assign hit = upd_en && (upd_lvl == prio_t'(l));
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          p_q <= PTR_RESET;
        end else if (hit) begin
          p_q <= upd_idx;
        end
      end
      assign ptr_q_flat[l*IDX_W +: IDX_W]   = p_q;
      assign ptr_eff_flat[l*IDX_W +: IDX_W] = hit ? upd_idx : p_q;
    end
  endgenerate
endmodule

// File: rtl/rr_picker.sv
module rr_picker #(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input  logic [N-1:0]     mask,
  input  logic [IDX_W-1:0] ptr,
  output logic [IDX_W-1:0] pick_idx,
  output logic             pick_vld
);
  function automatic logic [IDX_W:0] first_after(input logic [N-1:0] m,
                                                  input logic [IDX_W-1:0] p);
    logic [IDX_W:0] r;
    r = '0;
    for (int k = 1; k <= N; k++) begin
      int c;
      c = (int'(p) + k) % N;
      if (!r[IDX_W] && m[c]) begin
        r = {1'b1, IDX_W'(c)};
      end
    end
    return r;
  endfunction

  logic [IDX_W:0] res;
  assign res      = first_after(mask, ptr);
  assign pick_vld = res[IDX_W];
  assign pick_idx = res[IDX_W-1:0];
endmodule

// File: rtl/prio_rr_arbiter.sv
module prio_rr_arbiter
  import arb_pkg::*;
#(
  parameter int NUM_MASTERS = 4,
  parameter int IDX_W       = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   mode_burst,
  input  logic [NUM_MASTERS-1:0] req,
  input  logic [NUM_MASTERS-1:0] last,
  input  logic                   xfer_valid,
  input  logic                   xfer_ready,
  input  logic                   cfg_we,
  input  logic [IDX_W-1:0]       cfg_idx,
  input  logic [PRIO_W-1:0]      cfg_prio,
  output logic [NUM_MASTERS-1:0] grant
);
  localparam int N = NUM_MASTERS;

  function automatic logic [N-1:0] to_onehot(input logic [IDX_W-1:0] i);
    logic [N-1:0] v;
    v = '0;
    v[i] = 1'b1;
    return v;
  endfunction

  arb_mode_e                   mode;
  logic [N-1:0]                grant_q;
  logic [IDX_W-1:0]            gidx_q;
  prio_t                       glvl_q;
  logic                        granted_any;
  logic                        beat_done;
  logic                        burst_end;
  logic                        arb_point;
  logic [N*PRIO_W-1:0]         prio_flat;
  logic [NUM_LEVELS*N-1:0]     lvl_masks;
  prio_t                       best_lvl;
  logic                        any_req;
  logic [NUM_LEVELS*IDX_W-1:0] ptr_q_flat;
  logic [NUM_LEVELS*IDX_W-1:0] ptr_eff_flat;
  logic [IDX_W-1:0]            pick_idx;
  logic                        pick_vld;

  assign mode        = arb_mode_e'(mode_burst);
  assign granted_any = |grant_q;
  assign beat_done   = xfer_valid && xfer_ready && granted_any;
  assign burst_end   = beat_done && ((mode == ARB_PER_BEAT) || last[gidx_q]);
  assign arb_point   = !granted_any || burst_end;

  prio_cfg_regs #(.N(N), .IDX_W(IDX_W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (cfg_we),
    .wr_idx    (cfg_idx),
    .wr_val    (prio_t'(cfg_prio)),
    .prio_flat (prio_flat)
  );

  level_select #(.N(N)) u_lvl (
    .req       (req),
    .prio_flat (prio_flat),
    .lvl_masks (lvl_masks),
    .best_lvl  (best_lvl),
    .any_req   (any_req)
  );

  rr_pointer_bank #(.N(N), .IDX_W(IDX_W)) u_ptr (
    .clk          (clk),
    .rst_n        (rst_n),
    .upd_en       (beat_done),
    .upd_lvl      (glvl_q),
    .upd_idx      (gidx_q),
    .ptr_q_flat   (ptr_q_flat),
    .ptr_eff_flat (ptr_eff_flat)
  );

  rr_picker #(.N(N), .IDX_W(IDX_W)) u_pick (
    .mask     (lvl_masks[best_lvl*N +: N]),
    .ptr      (ptr_eff_flat[best_lvl*IDX_W +: IDX_W]),
    .pick_idx (pick_idx),
    .pick_vld (pick_vld)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grant_q <= '0;
      gidx_q  <= '0;
      glvl_q  <= PRIO_RESET;
    end else if (arb_point) begin
      grant_q <= (pick_vld && any_req) ? to_onehot(pick_idx) : '0;
      gidx_q  <= pick_idx;
      glvl_q  <= best_lvl;
    end
  end

  assign grant = grant_q;
endmodule

// File: rtl/arb_checker.sv
module arb_checker #(
  parameter int N      = 4,
  parameter int PTR_W  = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mode_burst,
  input logic [N-1:0]     req,
  input logic [N-1:0]     last,
  input logic [N-1:0]     grant,
  input logic             beat_done,
  input logic             arb_point,
  input logic [PTR_W-1:0] ptr_q_flat
);
  assert_grant_onehot0_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  assert_grant_requested_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant != '0) && (grant != $past(grant))) |-> (($past(req) & grant) != '0));

  assert_hold_no_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant != '0) && !beat_done) |=> $stable(grant));

  assert_burst_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_burst && beat_done && ((last & grant) == '0)) |=> $stable(grant));

  assert_serve_request_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_point && (req != '0)) |=> (grant != '0));

  assert_idle_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_point && (req == '0)) |=> (grant == '0));

  assert_ptr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !beat_done |=> $stable(ptr_q_flat));
endmodule

bind prio_rr_arbiter arb_checker #(
  .N     (NUM_MASTERS),
  .PTR_W (arb_pkg::NUM_LEVELS * IDX_W)
) u_arb_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode_burst (mode_burst),
  .req        (req),
  .last       (last),
  .grant      (grant),
  .beat_done  (beat_done),
  .arb_point  (arb_point),
  .ptr_q_flat (ptr_q_flat)
);

// File: tb/prio_rr_arbiter_bench.sv
`timescale 1ns/1ps
module prio_rr_arbiter_bench;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         mode_burst;
  logic [N-1:0] req;
  logic [N-1:0] last;
  logic         xfer_valid;
  logic         xfer_ready;
  logic         cfg_we;
  logic [1:0]   cfg_idx;
  logic [1:0]   cfg_prio;
  logic [N-1:0] grant;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  prio_rr_arbiter #(.NUM_MASTERS(N)) u_prio_rr_arbiter (
    .clk(clk), .rst_n(rst_n), .mode_burst(mode_burst), .req(req), .last(last),
    .xfer_valid(xfer_valid), .xfer_ready(xfer_ready), .cfg_we(cfg_we),
    .cfg_idx(cfg_idx), .cfg_prio(cfg_prio), .grant(grant)
  );

  // Arithmetic model of the requirements
  int m_prio [N];
  int m_ptr  [4];
  int m_idx;
  int m_lvl;
  bit m_vld;

  always @(posedge clk) begin
    bit done;
    bit arb;
    if (!rst_n) begin
      for (int i = 0; i < N; i++) m_prio[i] = 3;
      for (int l = 0; l < 4; l++) m_ptr[l] = N - 1;
      m_vld = 1'b0; m_idx = 0; m_lvl = 3;
    end else begin
      done = xfer_valid && xfer_ready && m_vld;
      if (done) m_ptr[m_lvl] = m_idx;
      arb = !m_vld || (done && (!mode_burst || last[m_idx]));
      if (arb) begin
        m_vld = 1'b0;
        for (int l = 0; l < 4; l++)
          for (int k = 1; k <= N; k++) begin
            int c;
            c = (m_ptr[l] + k) % N;
            if (!m_vld && req[c] && m_prio[c] == l) begin
              m_vld = 1'b1; m_idx = c; m_lvl = l;
            end
          end
      end
      if (cfg_we) m_prio[cfg_idx] = int'(cfg_prio);
    end
  end

  function automatic logic [N-1:0] model_grant();
    return m_vld ? (N'(1) << m_idx) : '0;
  endfunction

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s grant=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic tick(input string tag);
    @(posedge clk);
    @(negedge clk);
    chk(tag, grant, model_grant());
  endtask

  task automatic set_prio(input int idx, input int p, input string tag);
    cfg_we = 1'b1; cfg_idx = 2'(idx); cfg_prio = 2'(p);
    tick(tag);
    cfg_we = 1'b0;
  endtask

  task automatic rand_beats(input int n, input string tag);
    for (int t = 0; t < n; t++) begin
      req = 4'($urandom); last = 4'($urandom);
      xfer_valid = 1'($urandom); xfer_ready = ($urandom % 4) != 0;
      tick(tag);
    end
  endtask

  initial begin
    logic [N-1:0] held;
    rst_n = 1'b0; mode_burst = 1'b0; req = '0; last = '0;
    xfer_valid = 1'b0; xfer_ready = 1'b0; cfg_we = 1'b0; cfg_idx = '0; cfg_prio = '0;
    @(negedge clk);
    chk("R1", grant, '0);
    tick("R1");
    tick("R1");
    rst_n = 1'b1;
    chk("R1", grant, '0);
    // All at reset level 3: rotation 0,1,2,3,0 on each beat
    req = 4'hF; xfer_valid = 1'b1; xfer_ready = 1'b1;
    tick("R1");
    chk("R1", grant, 4'b0001);
    for (int t = 1; t < 8; t++) begin
      tick("R4");
      chk("R4", grant, 4'b0001 << (t % 4));
    end
    // Sweep every priority assignment
    for (int combo = 0; combo < 256; combo++) begin
      req = '0; xfer_valid = 1'b0;
      for (int i = 0; i < N; i++) set_prio(i, (combo >> (2*i)) & 3, "R9");
      mode_burst = 1'b0;
      rand_beats(6, "R3");
      rand_beats(4, "R5");
      mode_burst = 1'b1;
      rand_beats(8, "R6");
    end
    // Hold without completion
    mode_burst = 1'b0; req = 4'hF; xfer_valid = 1'b1; xfer_ready = 1'b1;
    tick("R7");
    held = grant; xfer_valid = 1'b0;
    for (int t = 0; t < 4; t++) begin
      tick("R7");
      chk("R7", grant, held);
    end
    // Idle: grant drops, then arbitration each cycle
    req = '0; xfer_valid = 1'b1;
    tick("R8");
    for (int t = 0; t < 3; t++) begin
      tick("R8");
      chk("R8", grant, '0);
    end
    xfer_valid = 1'b0; req = 4'b0100;
    tick("R10");
    chk("R10", grant, 4'b0100);
    // Priority change inside a locked burst
    req = '0; xfer_valid = 1'b1; last = 4'hF;
    tick("R9");
    for (int i = 0; i < N; i++) set_prio(i, 3, "R9");
    mode_burst = 1'b1; last = '0; req = 4'b0011;
    tick("R9");
    held = grant;
    set_prio((grant == 4'b0001) ? 1 : 0, 0, "R9");
    for (int t = 0; t < 3; t++) begin
      tick("R9");
      chk("R9", grant, held);
    end
    last = 4'hF;
    tick("R9");
    chk("R9", grant, (held == 4'b0001) ? 4'b0010 : 4'b0001);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #500000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule